// File: doc/BRIEF.md
# Cache Maintenance and Tag-Debug Unit

This block sits beside an instruction cache and a data cache and turns coprocessor-style register writes into single-cycle maintenance commands for them. Each access carries a 12-bit operation identifier together with 32 bits of data. A write either starts a command or updates a control register. The commands are invalidate all, invalidate by address and invalidate by set/way. Clean commands of the same three kinds are also issued, alone or together with the matching invalidate. The caches hold the tags and lines. This unit only issues the commands, and it passes clean commands on without giving them any effect of its own.

For debug, the unit holds an index register. A way and a line decoded from that register address one tag entry in either cache, so that entry can be read or overwritten directly. Two lockdown registers, one per cache, store whatever is written to them and change no behaviour. Reads return data in the cycle after the read strobe, qualified by a valid pulse.

Top module: `cache_maint_unit`

## Requirements
- R1: After reset, every command pulse, every tag write enable and `rvalid` are low. The debug index and both lockdown registers read back as zero.
- R2: A write to id 0x760 (data invalidate all), 0x761 (data invalidate by address) or 0x762 (data invalidate by set/way) raises the matching `dc_inv_*` pulse for exactly the one cycle after the write. For the by-address form, `cmd_addr` carries the written data during that pulse.
- R3: For a set/way command, `sw_way` is the value of data bits [31:30] and `sw_line` is the value of data bits [9:5], both presented alongside the pulse.
- R4: A write to id 0x770 raises `ic_inv_all` and `dc_inv_all` in the same cycle.
- R5: Ids 0x7A0, 0x7A1 and 0x7A2 raise `dc_cln_all`, `dc_cln_addr` and `dc_cln_sw` respectively. Ids 0x7E0, 0x7E1 and 0x7E2 raise that clean pulse and the invalidate pulse of the same kind in the same cycle, and the cache applies the clean first.
- R6: A write to id 0x7A3, or to any id not listed here, raises no pulse.
- R7: A set/way clean or invalidate whose line field is NUM_LINES or more, or whose way field is NUM_WAYS or more, raises no pulse.
- R8: Id 0xF00 (debug index), id 0x900 (data lockdown) and id 0x901 (instruction lockdown) store the whole 32-bit write and read it back. Writing them raises no pulse.
- R9: A write to id 0xF10 or 0xF20 gives a one-cycle `ic_tag_we` or `dc_tag_we`. During that pulse, `tag_wdata` is the written data and the target is `tag_way` = index[31:30], `tag_line` = index[9:5]. If that way or line is out of range, the write is dropped.
- R10: A read of id 0xF10 or 0xF20 returns, one cycle after the strobe, the tag supplied by the selected cache at the way and line of the debug index. The read returns zero when that way or line is out of range.
- R11: Each read gives `rvalid` for exactly one cycle, and a read of an id with no register returns zero. When `wr_en` and `rd_en` are both high, only the write is performed and `rvalid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| op_id | input | 12 | Operation or register identifier |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 32 | Read data |
| ic_inv_all | output | 1 | Instruction cache invalidate-all pulse |
| dc_inv_all | output | 1 | Data cache invalidate-all pulse |
| dc_inv_addr | output | 1 | Data cache invalidate-by-address pulse |
| dc_inv_sw | output | 1 | Data cache invalidate-by-set/way pulse |
| dc_cln_all | output | 1 | Data cache clean-all pulse |
| dc_cln_addr | output | 1 | Data cache clean-by-address pulse |
| dc_cln_sw | output | 1 | Data cache clean-by-set/way pulse |
| cmd_addr | output | 32 | Address for by-address commands |
| sw_way | output | WAY_W | Way for set/way commands |
| sw_line | output | LINE_W | Line for set/way commands |
| ic_tag_we | output | 1 | Instruction tag debug write enable |
| dc_tag_we | output | 1 | Data tag debug write enable |
| tag_way | output | WAY_W | Way of the tag selected by the debug index |
| tag_line | output | LINE_W | Line of the tag selected by the debug index |
| tag_wdata | output | 32 | Tag value to write |
| ic_tag_rdata | input | 32 | Instruction tag at `tag_way`/`tag_line` |
| dc_tag_rdata | input | 32 | Data tag at `tag_way`/`tag_line` |

## Verification
Several identifiers raise a clean pulse and an invalidate pulse in the same cycle, and 0x770 raises invalidate pulses for both caches at once. The bench drives each of these ids, alone and in back-to-back pairs. For every cycle it predicts the full set of pulses and compares it as a whole, so a missing partner, an extra pulse or a pulse lasting two cycles each show up as a mismatch. The same scoreboard checks that set/way fields out of range suppress both halves of a combined command.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

   localparam int ID_W   = 12;
   localparam int DATA_W = 32;

   // set/way field placement inside a data word
   localparam int WAY_FLD_MSB  = 31;
   localparam int WAY_FLD_W    = 2;
   localparam int LINE_FLD_LSB = 5;
   localparam int LINE_FLD_W   = 5;

   localparam logic [ID_W-1:0] ID_DINV_ALL  = 12'h760;
   localparam logic [ID_W-1:0] ID_DINV_ADDR = 12'h761;
   localparam logic [ID_W-1:0] ID_DINV_SW   = 12'h762;
   localparam logic [ID_W-1:0] ID_BOTH_INV  = 12'h770;
   localparam logic [ID_W-1:0] ID_DCLN_ALL  = 12'h7A0;
   localparam logic [ID_W-1:0] ID_DCLN_ADDR = 12'h7A1;
   localparam logic [ID_W-1:0] ID_DCLN_SW   = 12'h7A2;
   localparam logic [ID_W-1:0] ID_TEST_CLN  = 12'h7A3;
   localparam logic [ID_W-1:0] ID_DCI_ALL   = 12'h7E0;
   localparam logic [ID_W-1:0] ID_DCI_ADDR  = 12'h7E1;
   localparam logic [ID_W-1:0] ID_DCI_SW    = 12'h7E2;
   localparam logic [ID_W-1:0] ID_DLOCK     = 12'h900;
   localparam logic [ID_W-1:0] ID_ILOCK     = 12'h901;
   localparam logic [ID_W-1:0] ID_DBG_IDX   = 12'hF00;
   localparam logic [ID_W-1:0] ID_ITAG      = 12'hF10;
   localparam logic [ID_W-1:0] ID_DTAG      = 12'hF20;

   typedef struct packed {
      logic ic_inv_all;
      logic dc_inv_all;
      logic dc_inv_addr;
      logic dc_inv_sw;
      logic dc_cln_all;
      logic dc_cln_addr;
      logic dc_cln_sw;
      logic idx_wr;
      logic dlock_wr;
      logic ilock_wr;
      logic ic_tag_wr;
      logic dc_tag_wr;
   } wr_dec_t;

   typedef enum logic [2:0] {
      RSEL_ZERO,
      RSEL_IDX,
      RSEL_DLOCK,
      RSEL_ILOCK,
      RSEL_ITAG,
      RSEL_DTAG
   } rd_sel_e;

endpackage

// File: rtl/cmu_decode.sv
module cmu_decode
   import cmu_pkg::*;
(
   input  logic [ID_W-1:0] op_id,
   output wr_dec_t         wdec,
   output rd_sel_e         rsel
);

   always_comb begin
      wdec = '0;
      unique case (op_id)
         ID_DINV_ALL:  wdec.dc_inv_all  = 1'b1;
         ID_DINV_ADDR: wdec.dc_inv_addr = 1'b1;
         ID_DINV_SW:   wdec.dc_inv_sw   = 1'b1;
         ID_BOTH_INV: begin
            wdec.ic_inv_all = 1'b1;
            wdec.dc_inv_all = 1'b1;
         end
         ID_DCLN_ALL:  wdec.dc_cln_all  = 1'b1;
         ID_DCLN_ADDR: wdec.dc_cln_addr = 1'b1;
         ID_DCLN_SW:   wdec.dc_cln_sw   = 1'b1;
         ID_DCI_ALL: begin
            wdec.dc_cln_all = 1'b1;
            wdec.dc_inv_all = 1'b1;
         end
         ID_DCI_ADDR: begin
            wdec.dc_cln_addr = 1'b1;
            wdec.dc_inv_addr = 1'b1;
         end
         ID_DCI_SW: begin
            wdec.dc_cln_sw = 1'b1;
            wdec.dc_inv_sw = 1'b1;
         end
         ID_DLOCK:   wdec.dlock_wr  = 1'b1;
         ID_ILOCK:   wdec.ilock_wr  = 1'b1;
         ID_DBG_IDX: wdec.idx_wr    = 1'b1;
         ID_ITAG:    wdec.ic_tag_wr = 1'b1;
         ID_DTAG:    wdec.dc_tag_wr = 1'b1;
         default:    wdec = '0;   // includes the test-and-clean id
      endcase
   end

   always_comb begin
      unique case (op_id)
         ID_DBG_IDX: rsel = RSEL_IDX;
         ID_DLOCK:   rsel = RSEL_DLOCK;
         ID_ILOCK:   rsel = RSEL_ILOCK;
         ID_ITAG:    rsel = RSEL_ITAG;
         ID_DTAG:    rsel = RSEL_DTAG;
         default:    rsel = RSEL_ZERO;
      endcase
   end

endmodule

// File: rtl/cmu_setway.sv
module cmu_setway
   import cmu_pkg::*;
#(
   parameter int NUM_WAYS  = 4,
   parameter int NUM_LINES = 16,
   localparam int WAY_W  = $clog2(NUM_WAYS),
   localparam int LINE_W = $clog2(NUM_LINES)
)(
   input  logic [WAY_FLD_W-1:0]  way_fld,
   input  logic [LINE_FLD_W-1:0] line_fld,
   output logic [WAY_W-1:0]      way,
   output logic [LINE_W-1:0]     line,
   output logic                  in_range
);

   logic way_ok;
   logic line_ok;

   // a field that fills the whole structure needs no compare
   generate
      if (NUM_WAYS == (1 << WAY_FLD_W)) begin : g_way_full
         assign way_ok = 1'b1;
      end else begin : g_way_cmp
         assign way_ok = (int'(way_fld) < NUM_WAYS);
      end
      if (NUM_LINES == (1 << LINE_FLD_W)) begin : g_line_full
         assign line_ok = 1'b1;
      end else begin : g_line_cmp
         assign line_ok = (int'(line_fld) < NUM_LINES);
      end
   endgenerate

   assign way      = way_fld[WAY_W-1:0];
   assign line     = line_fld[LINE_W-1:0];
   assign in_range = way_ok & line_ok;

endmodule

// File: rtl/cmu_regs.sv
module cmu_regs
   import cmu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              idx_wr,
   input  logic              dlock_wr,
   input  logic              ilock_wr,
   input  rd_sel_e           rsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tag_ok,
   input  logic [DATA_W-1:0] ic_tag_rdata,
   input  logic [DATA_W-1:0] dc_tag_rdata,
   output logic [DATA_W-1:0] idx_q,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] dlock_q;
   logic [DATA_W-1:0] ilock_q;
   logic [DATA_W-1:0] rd_mux;
   logic              rd_go;

   assign rd_go = rd_en & ~wr_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         dlock_q <= '0;
         ilock_q <= '0;
      end else if (wr_en) begin
         if (idx_wr)   idx_q   <= wdata;
         if (dlock_wr) dlock_q <= wdata;
         if (ilock_wr) ilock_q <= wdata;
      end
   end

   always_comb begin
      unique case (rsel)
         RSEL_IDX:   rd_mux = idx_q;
         RSEL_DLOCK: rd_mux = dlock_q;
         RSEL_ILOCK: rd_mux = ilock_q;
         RSEL_ITAG:  rd_mux = tag_ok ? ic_tag_rdata : '0;
         RSEL_DTAG:  rd_mux = tag_ok ? dc_tag_rdata : '0;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= rd_go;
         if (rd_go) rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit
   import cmu_pkg::*;
#(
   parameter int NUM_WAYS    = 4,
   parameter int NUM_LINES   = 16,
   parameter bit CLEAN_PORTS = 1'b1,
   localparam int WAY_W  = $clog2(NUM_WAYS),
   localparam int LINE_W = $clog2(NUM_LINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [11:0]       op_id,
   input  logic [31:0]       wdata,
   output logic              rvalid,
   output logic [31:0]       rdata,
   output logic              ic_inv_all,
   output logic              dc_inv_all,
   output logic              dc_inv_addr,
   output logic              dc_inv_sw,
   output logic              dc_cln_all,
   output logic              dc_cln_addr,
   output logic              dc_cln_sw,
   output logic [31:0]       cmd_addr,
   output logic [WAY_W-1:0]  sw_way,
   output logic [LINE_W-1:0] sw_line,
   output logic              ic_tag_we,
   output logic              dc_tag_we,
   output logic [WAY_W-1:0]  tag_way,
   output logic [LINE_W-1:0] tag_line,
   output logic [31:0]       tag_wdata,
   input  logic [31:0]       ic_tag_rdata,
   input  logic [31:0]       dc_tag_rdata
);

   localparam int WAY_LSB = WAY_FLD_MSB - WAY_FLD_W + 1;
   localparam int LINE_MSB = LINE_FLD_LSB + LINE_FLD_W - 1;

   generate
      if (NUM_WAYS < 2 || NUM_WAYS > (1 << WAY_FLD_W)) begin : g_bad_ways
         $error("NUM_WAYS must lie between 2 and the way field capacity");
      end
      if (NUM_LINES < 2 || NUM_LINES > (1 << LINE_FLD_W)) begin : g_bad_lines
         $error("NUM_LINES must lie between 2 and the line field capacity");
      end
   endgenerate

   wr_dec_t           wdec;
   wr_dec_t           cmd_d;
   wr_dec_t           cmd_q;
   rd_sel_e           rsel;
   logic              cln_en;
   logic              sw_ok;
   logic              dbg_ok;
   logic [WAY_W-1:0]  sw_way_d;
   logic [LINE_W-1:0] sw_line_d;
   logic [31:0]       idx_q;

   cmu_decode u_decode (
      .op_id (op_id),
      .wdec  (wdec),
      .rsel  (rsel)
   );

   cmu_setway #(.NUM_WAYS(NUM_WAYS), .NUM_LINES(NUM_LINES)) u_sw_cmd (
      .way_fld  (wdata[WAY_FLD_MSB:WAY_LSB]),
      .line_fld (wdata[LINE_MSB:LINE_FLD_LSB]),
      .way      (sw_way_d),
      .line     (sw_line_d),
      .in_range (sw_ok)
   );

   cmu_setway #(.NUM_WAYS(NUM_WAYS), .NUM_LINES(NUM_LINES)) u_sw_dbg (
      .way_fld  (idx_q[WAY_FLD_MSB:WAY_LSB]),
      .line_fld (idx_q[LINE_MSB:LINE_FLD_LSB]),
      .way      (tag_way),
      .line     (tag_line),
      .in_range (dbg_ok)
   );

   cmu_regs u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .rd_en        (rd_en),
      .idx_wr       (wdec.idx_wr),
      .dlock_wr     (wdec.dlock_wr),
      .ilock_wr     (wdec.ilock_wr),
      .rsel         (rsel),
      .wdata        (wdata),
      .tag_ok       (dbg_ok),
      .ic_tag_rdata (ic_tag_rdata),
      .dc_tag_rdata (dc_tag_rdata),
      .idx_q        (idx_q),
      .rvalid       (rvalid),
      .rdata        (rdata)
   );

   // variant: clean commands forwarded or suppressed at the edge
   generate
      if (CLEAN_PORTS) begin : g_clean_on
         assign cln_en = 1'b1;
      end else begin : g_clean_off
         assign cln_en = 1'b0;
      end
   endgenerate

   always_comb begin
      cmd_d = wr_en ? wdec : '0;
      cmd_d.dc_inv_sw   = cmd_d.dc_inv_sw & sw_ok;
      cmd_d.dc_cln_sw   = cmd_d.dc_cln_sw & sw_ok & cln_en;
      cmd_d.dc_cln_all  = cmd_d.dc_cln_all & cln_en;
      cmd_d.dc_cln_addr = cmd_d.dc_cln_addr & cln_en;
      cmd_d.ic_tag_wr   = cmd_d.ic_tag_wr & dbg_ok;
      cmd_d.dc_tag_wr   = cmd_d.dc_tag_wr & dbg_ok;
      cmd_d.idx_wr      = 1'b0;
      cmd_d.dlock_wr    = 1'b0;
      cmd_d.ilock_wr    = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         cmd_addr  <= '0;
         sw_way    <= '0;
         sw_line   <= '0;
         tag_wdata <= '0;
      end else begin
         cmd_q <= cmd_d;
         if (cmd_d.dc_inv_addr | cmd_d.dc_cln_addr) cmd_addr <= wdata;
         if (cmd_d.dc_inv_sw | cmd_d.dc_cln_sw) begin
            sw_way  <= sw_way_d;
            sw_line <= sw_line_d;
         end
         if (cmd_d.ic_tag_wr | cmd_d.dc_tag_wr) tag_wdata <= wdata;
      end
   end

   assign ic_inv_all  = cmd_q.ic_inv_all;
   assign dc_inv_all  = cmd_q.dc_inv_all;
   assign dc_inv_addr = cmd_q.dc_inv_addr;
   assign dc_inv_sw   = cmd_q.dc_inv_sw;
   assign dc_cln_all  = cmd_q.dc_cln_all;
   assign dc_cln_addr = cmd_q.dc_cln_addr;
   assign dc_cln_sw   = cmd_q.dc_cln_sw;
   assign ic_tag_we   = cmd_q.ic_tag_wr;
   assign dc_tag_we   = cmd_q.dc_tag_wr;

endmodule

// File: rtl/cmu_checker.sv
module cmu_checker
   import cmu_pkg::*;
#(
   parameter int NUM_WAYS    = 4,
   parameter int NUM_LINES   = 16,
   parameter bit CLEAN_PORTS = 1'b1
)(
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        rd_en,
   input logic [11:0] op_id,
   input logic [1:0]  way_fld,
   input logic [4:0]  line_fld,
   input logic        ic_inv_all,
   input logic        dc_inv_all,
   input logic        dc_inv_addr,
   input logic        dc_inv_sw,
   input logic        dc_cln_all,
   input logic        dc_cln_addr,
   input logic        dc_cln_sw,
   input logic        ic_tag_we,
   input logic        dc_tag_we,
   input logic        rvalid
);

   logic        p_wr;
   logic        p_rd;
   logic [11:0] p_id;
   logic [1:0]  p_way;
   logic [4:0]  p_line;
   logic        any_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_wr   <= 1'b0;
         p_rd   <= 1'b0;
         p_id   <= '0;
         p_way  <= '0;
         p_line <= '0;
      end else begin
         p_wr   <= wr_en;
         p_rd   <= rd_en;
         p_id   <= op_id;
         p_way  <= way_fld;
         p_line <= line_fld;
      end
   end

   assign any_pulse = ic_inv_all | dc_inv_all | dc_inv_addr | dc_inv_sw |
                      dc_cln_all | dc_cln_addr | dc_cln_sw;

   AST_DC_ALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      dc_inv_all |-> (p_wr && (p_id == ID_DINV_ALL || p_id == ID_BOTH_INV || p_id == ID_DCI_ALL))); // R2

   AST_IC_WITH_DC: assert property (@(posedge clk) disable iff (!rst_n)
      ic_inv_all |-> dc_inv_all); // R4

   AST_PAIR_BY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr && p_id == ID_DCI_ADDR) |-> (dc_inv_addr && (dc_cln_addr || !CLEAN_PORTS))); // R5

   AST_TEST_CLEAN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr && p_id == ID_TEST_CLN) |-> !any_pulse); // R6

   AST_SW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_inv_sw || dc_cln_sw) |-> (int'(p_line) < NUM_LINES && int'(p_way) < NUM_WAYS)); // R7

   AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr && (p_id == ID_DLOCK || p_id == ID_ILOCK || p_id == ID_DBG_IDX))
      |-> (!any_pulse && !ic_tag_we && !dc_tag_we)); // R8

   AST_TAG_WE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      ic_tag_we |-> (p_wr && p_id == ID_ITAG)); // R9

   AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> (p_rd && !p_wr)); // R11

endmodule

bind cache_maint_unit cmu_checker #(
   .NUM_WAYS    (NUM_WAYS),
   .NUM_LINES   (NUM_LINES),
   .CLEAN_PORTS (CLEAN_PORTS)
) u_cmu_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .op_id       (op_id),
   .way_fld     (wdata[31:30]),
   .line_fld    (wdata[9:5]),
   .ic_inv_all  (ic_inv_all),
   .dc_inv_all  (dc_inv_all),
   .dc_inv_addr (dc_inv_addr),
   .dc_inv_sw   (dc_inv_sw),
   .dc_cln_all  (dc_cln_all),
   .dc_cln_addr (dc_cln_addr),
   .dc_cln_sw   (dc_cln_sw),
   .ic_tag_we   (ic_tag_we),
   .dc_tag_we   (dc_tag_we),
   .rvalid      (rvalid)
);

// File: tb/cache_maint_unit_bench.sv
module cache_maint_unit_bench;

   localparam int NW = 4;
   localparam int NL = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] op_id = '0;
   logic [31:0] wdata = '0;
   logic        rvalid;
   logic [31:0] rdata;
   logic        ic_inv_all, dc_inv_all, dc_inv_addr, dc_inv_sw;
   logic        dc_cln_all, dc_cln_addr, dc_cln_sw;
   logic [31:0] cmd_addr;
   logic [1:0]  sw_way, tag_way;
   logic [3:0]  sw_line, tag_line;
   logic        ic_tag_we, dc_tag_we;
   logic [31:0] tag_wdata;
   logic [31:0] ic_tag_rdata, dc_tag_rdata;

   always #5 clk = ~clk;

   cache_maint_unit #(.NUM_WAYS(NW), .NUM_LINES(NL)) u_cache_maint_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .op_id(op_id),
      .wdata(wdata), .rvalid(rvalid), .rdata(rdata),
      .ic_inv_all(ic_inv_all), .dc_inv_all(dc_inv_all), .dc_inv_addr(dc_inv_addr),
      .dc_inv_sw(dc_inv_sw), .dc_cln_all(dc_cln_all), .dc_cln_addr(dc_cln_addr),
      .dc_cln_sw(dc_cln_sw), .cmd_addr(cmd_addr), .sw_way(sw_way), .sw_line(sw_line),
      .ic_tag_we(ic_tag_we), .dc_tag_we(dc_tag_we), .tag_way(tag_way),
      .tag_line(tag_line), .tag_wdata(tag_wdata),
      .ic_tag_rdata(ic_tag_rdata), .dc_tag_rdata(dc_tag_rdata)
   );

   // stand-in tag arrays of the two caches
   logic [31:0] ic_mem [NW][NL];
   logic [31:0] dc_mem [NW][NL];
   initial begin
      for (int w = 0; w < NW; w++)
         for (int l = 0; l < NL; l++) begin
            ic_mem[w][l] = '0;
            dc_mem[w][l] = '0;
         end
   end
   always @(posedge clk) begin
      if (ic_tag_we) ic_mem[tag_way][tag_line] <= tag_wdata;
      if (dc_tag_we) dc_mem[tag_way][tag_line] <= tag_wdata;
   end
   assign ic_tag_rdata = ic_mem[tag_way][tag_line];
   assign dc_tag_rdata = dc_mem[tag_way][tag_line];

   // pulse vector order: ic_inv_all dc_inv_all dc_inv_addr dc_inv_sw dc_cln_all dc_cln_addr dc_cln_sw
   typedef struct {
      logic [6:0]  pulse;
      logic [1:0]  twe;
      logic        rv;
      logic [31:0] rd;
      logic [31:0] addr;
      logic [1:0]  way;
      logic [3:0]  line;
      logic [31:0] twd;
      string       req;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;

   logic [31:0] m_idx = '0, m_dl = '0, m_il = '0;
   logic [31:0] m_ic [NW][NL];
   logic [31:0] m_dc [NW][NL];
   initial begin
      for (int w = 0; w < NW; w++)
         for (int l = 0; l < NL; l++) begin
            m_ic[w][l] = '0;
            m_dc[w][l] = '0;
         end
   end

   function automatic bit fld_ok(input logic [31:0] v);
      return (int'(v[31:30]) < NW) && (int'(v[9:5]) < NL);
   endfunction

   task automatic op(input logic w, input logic r, input logic [11:0] id,
                     input logic [31:0] d, input string req);
      exp_t e;
      @(negedge clk);
      wr_en = w; rd_en = r; op_id = id; wdata = d;
      e.pulse = '0; e.twe = '0; e.rv = 1'b0; e.rd = '0; e.addr = '0;
      e.way = '0; e.line = '0; e.twd = '0; e.req = req;
      if (w) begin
         case (id)
            12'h760: e.pulse[5] = 1'b1;
            12'h761: begin e.pulse[4] = 1'b1; e.addr = d; end
            12'h762: if (fld_ok(d)) begin e.pulse[3] = 1'b1; e.way = d[31:30]; e.line = d[8:5]; end
            12'h770: begin e.pulse[6] = 1'b1; e.pulse[5] = 1'b1; end
            12'h7A0: e.pulse[2] = 1'b1;
            12'h7A1: begin e.pulse[1] = 1'b1; e.addr = d; end
            12'h7A2: if (fld_ok(d)) begin e.pulse[0] = 1'b1; e.way = d[31:30]; e.line = d[8:5]; end
            12'h7E0: begin e.pulse[5] = 1'b1; e.pulse[2] = 1'b1; end
            12'h7E1: begin e.pulse[4] = 1'b1; e.pulse[1] = 1'b1; e.addr = d; end
            12'h7E2: if (fld_ok(d)) begin e.pulse[3] = 1'b1; e.pulse[0] = 1'b1; e.way = d[31:30]; e.line = d[8:5]; end
            12'h900: m_dl = d;
            12'h901: m_il = d;
            12'hF00: m_idx = d;
            12'hF10: if (fld_ok(m_idx)) begin
               e.twe[1] = 1'b1; e.twd = d; m_ic[m_idx[31:30]][m_idx[8:5]] = d;
            end
            12'hF20: if (fld_ok(m_idx)) begin
               e.twe[0] = 1'b1; e.twd = d; m_dc[m_idx[31:30]][m_idx[8:5]] = d;
            end
            default: ;
         endcase
      end else if (r) begin
         e.rv = 1'b1;
         case (id)
            12'hF00: e.rd = m_idx;
            12'h900: e.rd = m_dl;
            12'h901: e.rd = m_il;
            12'hF10: e.rd = fld_ok(m_idx) ? m_ic[m_idx[31:30]][m_idx[8:5]] : '0;
            12'hF20: e.rd = fld_ok(m_idx) ? m_dc[m_idx[31:30]][m_idx[8:5]] : '0;
            default: e.rd = '0;
         endcase
      end
      q.push_back(e);
   endtask

   task automatic idle(input string req);
      op(1'b0, 1'b0, 12'h000, 32'h0, req);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: one expected item per cycle
   initial begin
      exp_t e;
      logic [6:0] p;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            p = {ic_inv_all, dc_inv_all, dc_inv_addr, dc_inv_sw, dc_cln_all, dc_cln_addr, dc_cln_sw};
            check(p === e.pulse, e.req, "pulses", {25'b0, p}, {25'b0, e.pulse});
            check({ic_tag_we, dc_tag_we} === e.twe, e.req, "tag_we", {30'b0, ic_tag_we, dc_tag_we}, {30'b0, e.twe});
            check(rvalid === e.rv, e.req, "rvalid", {31'b0, rvalid}, {31'b0, e.rv});
            if (e.rv) check(rdata === e.rd, e.req, "rdata", rdata, e.rd);
            if (e.pulse[4] | e.pulse[1]) check(cmd_addr === e.addr, e.req, "cmd_addr", cmd_addr, e.addr);
            if (e.pulse[3] | e.pulse[0]) begin
               check(sw_way === e.way, e.req, "sw_way", {30'b0, sw_way}, {30'b0, e.way});
               check(sw_line === e.line, e.req, "sw_line", {28'b0, sw_line}, {28'b0, e.line});
            end
            if (|e.twe) check(tag_wdata === e.twd, e.req, "tag_wdata", tag_wdata, e.twd);
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      idle("R1");
      op(0, 1, 12'hF00, 0, "R1");
      op(0, 1, 12'h900, 0, "R1");
      op(0, 1, 12'h901, 0, "R1");
      // R2 data invalidates
      op(1, 0, 12'h761, 32'h1234_5660, "R2");
      idle("R2");
      op(1, 0, 12'h760, 32'h0, "R2");
      idle("R2");
      op(1, 0, 12'h761, 32'hDEAD_BEE0, "R2");
      op(1, 0, 12'h761, 32'h0000_0040, "R2");
      idle("R2");
      // R3 set/way fields
      op(1, 0, 12'h762, (32'd2 << 30) | (32'd7 << 5), "R3");
      op(1, 0, 12'h762, (32'd3 << 30) | (32'd15 << 5) | 32'h1F, "R3");
      idle("R3");
      // R4 both caches
      op(1, 0, 12'h770, 32'hFFFF_FFFF, "R4");
      idle("R4");
      // R5 clean and clean+invalidate
      op(1, 0, 12'h7A0, 0, "R5");
      op(1, 0, 12'h7A1, 32'h0800_0020, "R5");
      op(1, 0, 12'h7A2, (32'd1 << 30) | (32'd9 << 5), "R5");
      op(1, 0, 12'h7E0, 0, "R5");
      op(1, 0, 12'h7E1, 32'h0200_1000, "R5");
      op(1, 0, 12'h7E2, (32'd0 << 30) | (32'd4 << 5), "R5");
      idle("R5");
      // R6 no-op ids
      op(1, 0, 12'h7A3, 32'hFFFF_FFFF, "R6");
      op(1, 0, 12'h123, 32'hFFFF_FFFF, "R6");
      op(1, 0, 12'h750, 32'h0, "R6");
      idle("R6");
      // R7 out-of-range set/way
      op(1, 0, 12'h762, (32'd1 << 30) | (32'd20 << 5), "R7");
      op(1, 0, 12'h7E2, (32'd3 << 30) | (32'd31 << 5), "R7");
      op(1, 0, 12'h7A2, (32'd0 << 30) | (32'd16 << 5), "R7");
      idle("R7");
      // R8 registers
      op(1, 0, 12'h900, 32'hA5A5_0F0F, "R8");
      op(1, 0, 12'h901, 32'h1357_9BDF, "R8");
      op(0, 1, 12'h900, 0, "R8");
      op(0, 1, 12'h901, 0, "R8");
      op(1, 0, 12'hF00, 32'h8765_4321, "R8");
      op(0, 1, 12'hF00, 0, "R8");
      // R9 / R10 tag debug
      op(1, 0, 12'hF00, (32'd1 << 30) | (32'd3 << 5), "R9");
      op(1, 0, 12'hF10, 32'hCAFE_0010, "R9");
      idle("R9");
      op(1, 0, 12'hF20, 32'hBEEF_0020, "R9");
      idle("R9");
      op(0, 1, 12'hF10, 0, "R10");
      op(0, 1, 12'hF20, 0, "R10");
      op(1, 0, 12'hF00, (32'd3 << 30) | (32'd15 << 5), "R9");
      op(1, 0, 12'hF10, 32'h0F0F_1234, "R9");
      idle("R9");
      op(0, 1, 12'hF10, 0, "R10");
      op(0, 1, 12'hF20, 0, "R10");
      op(1, 0, 12'hF00, (32'd0 << 30) | (32'd20 << 5), "R9");
      op(1, 0, 12'hF10, 32'h5555_AAAA, "R9");
      idle("R9");
      op(0, 1, 12'hF10, 0, "R10");
      op(1, 0, 12'hF00, (32'd0 << 30) | (32'd4 << 5), "R9");
      op(0, 1, 12'hF10, 0, "R9");
      op(1, 0, 12'hF00, (32'd1 << 30) | (32'd3 << 5), "R10");
      op(0, 1, 12'hF10, 0, "R10");
      // R11 read rules
      op(0, 1, 12'h7A0, 0, "R11");
      op(0, 1, 12'h555, 0, "R11");
      op(1, 1, 12'h900, 32'h0BAD_F00D, "R11");
      op(0, 1, 12'h900, 0, "R11");
      idle("R11");
      idle("R11");
      wait (q.size() == 0);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule